// File: doc/BRIEF.md
# CEC Header Address Filter

This block sits behind a CEC bit-level receiver and decides, once each incoming header has been decoded, whether the frame is taken in and whether the node pulls the acknowledge slot. The receiver hands over header bits one at a time as a valid/value strobe. The filter shifts in the initiator and destination logical addresses and checks the destination against a 15-entry own-address bitmap. It has its decision and its acknowledge request ready before the acknowledge slot arrives.

A single configuration word carries the enable, a listen option, a signal-free-time trigger option and the bitmap. With listen set, frames for other nodes are still taken in but are never acknowledged. Broadcast frames are always taken in. Software may only rewrite the configuration while the block is off. Turning the block off discards any header in progress and clears the decision outputs. The block also raises a one-cycle trigger that starts an external signal-free-time timer. It fires either on a software transmit-start request or on the end of any message, as the option bit selects.

Top module: `cec_hdr_filter`

## Requirements
- R1: After reset the block is disabled with an empty bitmap and listen off, and rx_accept, ack_drive, hdr_valid, sft_start, init_addr and dest_addr are all zero. Header bits and messages have no effect while the block is disabled.
- R2: Configuration word layout: bit 0 enable, bit 1 listen, bit 2 signal-free-time auto option, bits 17:3 own-address bitmap, where bitmap bit n enables logical address n. When the destination is an enabled own address, rx_accept and ack_drive are both set.
- R3: The decision (hdr_valid pulse, rx_accept, ack_drive) appears in the cycle after the ninth header bit (the end-of-message bit) is strobed. ack_drive clears in the cycle after the tenth bit (the acknowledge slot) is strobed, and rx_accept stays set.
- R4: If the destination is not an enabled own address, is not broadcast, and listen is off, then rx_accept and ack_drive stay zero.
- R5: If the destination is not an enabled own address, is not broadcast, and listen is on, then rx_accept is set and ack_drive stays zero.
- R6: Destination 0xF is broadcast. It is always accepted and never acknowledged, whatever the bitmap and listen settings.
- R7: Header bits arrive MSB first: the first four form init_addr and the next four form dest_addr. Both are presented with the decision.
- R8: While the block is enabled, a configuration write changes only the enable bit. The listen, option and bitmap fields in the write are ignored.
- R9: Clearing enable aborts a header in progress and clears rx_accept and ack_drive. After re-enabling, the next strobed bit is taken as the first bit of a new header.
- R10: Bits strobed after the acknowledge slot produce no further decision. msg_done clears rx_accept and restarts header capture.
- R11: While enabled, sft_start pulses one cycle after tx_som when the option is 0, and one cycle after msg_done when the option is 1. The other event does not trigger it, and nothing triggers it while the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 18 | Configuration word |
| bit_vld | input | 1 | Decoded bit strobe from receiver |
| bit_val | input | 1 | Decoded bit value |
| msg_done | input | 1 | End of a message (transmitted or received) |
| tx_som | input | 1 | Software transmit-start request |
| rx_accept | output | 1 | Current message is being received |
| ack_drive | output | 1 | Drive acknowledge in the ACK slot |
| hdr_valid | output | 1 | One-cycle pulse: header decision made |
| init_addr | output | 4 | Captured initiator address |
| dest_addr | output | 4 | Captured destination address |
| sft_start | output | 1 | Signal-free-time timer start trigger |

## Verification
The hardest cases to reach from the ports are an abort that leaves a partial header behind, and a configuration write that lands while the block is running. For the abort, the bench strobes five header bits, disables the block and re-enables it. It then sends a header whose addresses would be misread if any stale bit survived. For the ignored write, the bench rewrites the word while enabled with an empty bitmap and listen on. It then shows that the old bitmap still decides the acknowledge and that a foreign frame is still dropped. A scoreboard queue predicts every decision from a model of the configuration. An unexpected decision pulse, such as one from data bits after the acknowledge slot, is reported.

// File: rtl/cec_filt_pkg.sv
package cec_filt_pkg;

   typedef enum logic [1:0] {
      DEC_DROP   = 2'd0,
      DEC_OWN    = 2'd1,
      DEC_LISTEN = 2'd2,
      DEC_BCAST  = 2'd3
   } cec_dec_e;

   localparam int CFG_EN_BIT  = 0;
   localparam int CFG_LSN_BIT = 1;
   localparam int CFG_SFT_BIT = 2;
   localparam int CFG_MAP_LSB = 3;

   function automatic logic dec_accept(cec_dec_e d);
      return d != DEC_DROP;
   endfunction

   function automatic logic dec_ack(cec_dec_e d);
      return d == DEC_OWN;
   endfunction

endpackage

// File: rtl/cec_filt_cfg.sv
module cec_filt_cfg
   import cec_filt_pkg::*;
#(
   parameter int N_ADDR = 15,
   parameter int CFG_W  = N_ADDR + CFG_MAP_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CFG_W-1:0]  wdata,
   output logic              en,
   output logic              listen,
   output logic              sft_auto,
   output logic [N_ADDR-1:0] own_map
);

   if (CFG_W != N_ADDR + CFG_MAP_LSB) begin : g_bad_cfg_w
      $error("cec_filt_cfg: CFG_W must equal N_ADDR + CFG_MAP_LSB");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         listen   <= 1'b0;
         sft_auto <= 1'b0;
         own_map  <= '0;
      end else if (we) begin
         en <= wdata[CFG_EN_BIT];
         if (!en) begin
            listen   <= wdata[CFG_LSN_BIT];
            sft_auto <= wdata[CFG_SFT_BIT];
            own_map  <= wdata[CFG_MAP_LSB +: N_ADDR];
         end
      end
   end

endmodule

// File: rtl/cec_filt_match.sv
module cec_filt_match
   import cec_filt_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int N_ADDR     = (1 << ADDR_W) - 1,
   parameter int MATCH_IMPL = 0
) (
   input  logic [ADDR_W-1:0] dest,
   input  logic [N_ADDR-1:0] own_map,
   input  logic              listen,
   output cec_dec_e          dec
);

   localparam int SLOTS = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] BCAST = ADDR_W'(SLOTS - 1);

   logic hit;
   logic bcast;

   if (MATCH_IMPL == 0) begin : g_mux
      logic [SLOTS-1:0] map_x;
      assign map_x = SLOTS'(own_map);
      assign hit   = map_x[dest];
   end else begin : g_decode
      logic [N_ADDR-1:0] hit_vec;
      for (genvar g = 0; g < N_ADDR; g++) begin : g_slot
         assign hit_vec[g] = own_map[g] && (dest == ADDR_W'(g));
      end
      assign hit = |hit_vec;
   end

   assign bcast = (dest == BCAST);

   always_comb begin
      if (bcast)       dec = DEC_BCAST;
      else if (hit)    dec = DEC_OWN;
      else if (listen) dec = DEC_LISTEN;
      else             dec = DEC_DROP;
   end

endmodule

// File: rtl/cec_filt_seq.sv
module cec_filt_seq
   import cec_filt_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int HDR_BITS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              bit_vld,
   input  logic              bit_val,
   input  logic              msg_done,
   input  cec_dec_e          dec,
   output logic [ADDR_W-1:0] hdr_dest,
   output logic              rx_accept,
   output logic              ack_drive,
   output logic              hdr_valid,
   output logic [ADDR_W-1:0] init_addr,
   output logic [ADDR_W-1:0] dest_addr
);

   localparam int ADDR_BITS = 2 * ADDR_W;
   localparam int EOM_IDX   = ADDR_BITS;
   localparam int ACK_IDX   = EOM_IDX + 1;
   localparam int CNT_W     = $clog2(HDR_BITS + 1);

   if (HDR_BITS != ACK_IDX + 1) begin : g_bad_hdr
      $error("cec_filt_seq: HDR_BITS must be 2*ADDR_W + 2");
   end

   logic [CNT_W-1:0]     cnt;
   logic [ADDR_BITS-1:0] shreg;

   assign hdr_dest = shreg[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         shreg     <= '0;
         rx_accept <= 1'b0;
         ack_drive <= 1'b0;
         hdr_valid <= 1'b0;
         init_addr <= '0;
         dest_addr <= '0;
      end else if (!en) begin
         cnt       <= '0;
         shreg     <= '0;
         rx_accept <= 1'b0;
         ack_drive <= 1'b0;
         hdr_valid <= 1'b0;
         init_addr <= '0;
         dest_addr <= '0;
      end else if (msg_done) begin
         cnt       <= '0;
         shreg     <= '0;
         rx_accept <= 1'b0;
         ack_drive <= 1'b0;
         hdr_valid <= 1'b0;
      end else begin
         hdr_valid <= 1'b0;
         if (bit_vld && (cnt < CNT_W'(HDR_BITS))) begin
            cnt <= cnt + 1'b1;
            if (cnt < CNT_W'(ADDR_BITS)) begin
               shreg <= {shreg[ADDR_BITS-2:0], bit_val};
            end
            if (cnt == CNT_W'(EOM_IDX)) begin
               rx_accept <= dec_accept(dec);
               ack_drive <= dec_ack(dec);
               hdr_valid <= 1'b1;
               init_addr <= shreg[ADDR_BITS-1:ADDR_W];
               dest_addr <= shreg[ADDR_W-1:0];
            end
            if (cnt == CNT_W'(ACK_IDX)) begin
               ack_drive <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/cec_filt_sft.sv
module cec_filt_sft (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sft_auto,
   input  logic tx_som,
   input  logic msg_done,
   output logic sft_start
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sft_start <= 1'b0;
      else        sft_start <= en && (sft_auto ? msg_done : tx_som);
   end

endmodule

// File: rtl/cec_hdr_filter.sv
module cec_hdr_filter
   import cec_filt_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int HDR_BITS   = 2 * ADDR_W + 2,
   parameter int MATCH_IMPL = 0,
   parameter int N_ADDR     = (1 << ADDR_W) - 1,
   parameter int CFG_W      = N_ADDR + CFG_MAP_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              bit_vld,
   input  logic              bit_val,
   input  logic              msg_done,
   input  logic              tx_som,
   output logic              rx_accept,
   output logic              ack_drive,
   output logic              hdr_valid,
   output logic [ADDR_W-1:0] init_addr,
   output logic [ADDR_W-1:0] dest_addr,
   output logic              sft_start
);

   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("cec_hdr_filter: ADDR_W must be at least 2");
   end
   if (N_ADDR != (1 << ADDR_W) - 1) begin : g_bad_n_addr
      $error("cec_hdr_filter: N_ADDR must be 2**ADDR_W - 1");
   end
   if (MATCH_IMPL < 0 || MATCH_IMPL > 1) begin : g_bad_impl
      $error("cec_hdr_filter: MATCH_IMPL must be 0 or 1");
   end

   logic              cfg_en;
   logic              cfg_listen;
   logic              cfg_sft_auto;
   logic [N_ADDR-1:0] cfg_map;
   logic [ADDR_W-1:0] hdr_dest;
   cec_dec_e          dec;

   cec_filt_cfg #(.N_ADDR(N_ADDR), .CFG_W(CFG_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .wdata    (cfg_wdata),
      .en       (cfg_en),
      .listen   (cfg_listen),
      .sft_auto (cfg_sft_auto),
      .own_map  (cfg_map)
   );

   cec_filt_match #(.ADDR_W(ADDR_W), .N_ADDR(N_ADDR), .MATCH_IMPL(MATCH_IMPL)) u_match (
      .dest    (hdr_dest),
      .own_map (cfg_map),
      .listen  (cfg_listen),
      .dec     (dec)
   );

   cec_filt_seq #(.ADDR_W(ADDR_W), .HDR_BITS(HDR_BITS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cfg_en),
      .bit_vld   (bit_vld),
      .bit_val   (bit_val),
      .msg_done  (msg_done),
      .dec       (dec),
      .hdr_dest  (hdr_dest),
      .rx_accept (rx_accept),
      .ack_drive (ack_drive),
      .hdr_valid (hdr_valid),
      .init_addr (init_addr),
      .dest_addr (dest_addr)
   );

   cec_filt_sft u_sft (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cfg_en),
      .sft_auto  (cfg_sft_auto),
      .tx_som    (tx_som),
      .msg_done  (msg_done),
      .sft_start (sft_start)
   );

endmodule

// File: rtl/cec_filt_chk.sv
module cec_filt_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en,
   input logic              rx_accept,
   input logic              ack_drive,
   input logic              hdr_valid,
   input logic [ADDR_W-1:0] dest_addr,
   input logic              sft_start
);

   // R2
   ack_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_drive |-> rx_accept);

   // R6
   bcast_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_accept && dest_addr == {ADDR_W{1'b1}}) |-> !ack_drive);

   // R3
   ack_with_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_drive) |-> hdr_valid);

   // R9
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> (!rx_accept && !ack_drive && !hdr_valid));

   // R10
   single_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> !hdr_valid);

   // R11
   sft_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sft_start |-> $past(cfg_en));

endmodule

bind cec_hdr_filter cec_filt_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_en    (cfg_en),
   .rx_accept (rx_accept),
   .ack_drive (ack_drive),
   .hdr_valid (hdr_valid),
   .dest_addr (dest_addr),
   .sft_start (sft_start)
);

// File: tb/cec_hdr_filter_tb.sv
module cec_hdr_filter_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [17:0] cfg_wdata;
   logic        bit_vld, bit_val, msg_done, tx_som;
   logic        rx_accept, ack_drive, hdr_valid, sft_start;
   logic [3:0]  init_addr, dest_addr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      bit       acc;
      bit       ack;
      bit [3:0] ini;
      bit [3:0] dst;
   } exp_t;

   exp_t exp_q[$];
   exp_t mon_e;

   bit        m_en, m_lsn, m_auto;
   bit [14:0] m_map;

   always #(CLK_PERIOD/2) clk = ~clk;

   cec_hdr_filter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .bit_vld(bit_vld), .bit_val(bit_val), .msg_done(msg_done), .tx_som(tx_som),
      .rx_accept(rx_accept), .ack_drive(ack_drive), .hdr_valid(hdr_valid),
      .init_addr(init_addr), .dest_addr(dest_addr), .sft_start(sft_start)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit [17:0] mk(bit en, bit lsn, bit aut, bit [14:0] map);
      return {map, aut, lsn, en};
   endfunction

   function automatic exp_t predict(bit [3:0] i, bit [3:0] d);
      exp_t e;
      e.ini = i; e.dst = d;
      if (d == 4'hF)       begin e.acc = 1; e.ack = 0; end
      else if (m_map[d])   begin e.acc = 1; e.ack = 1; end
      else if (m_lsn)      begin e.acc = 1; e.ack = 0; end
      else                 begin e.acc = 0; e.ack = 0; end
      return e;
   endfunction

   // monitor: every decision pulse must match the oldest prediction
   always @(negedge clk) begin
      if (rst_n && hdr_valid) begin
         if (exp_q.size() == 0) begin
            chk("R10", "unexpected decision pulse", 1, 0);
         end else begin
            mon_e = exp_q.pop_front();
            chk("R7", "init_addr", init_addr, mon_e.ini);
            chk("R7", "dest_addr", dest_addr, mon_e.dst);
            chk("R2", "rx_accept at decision", rx_accept, mon_e.acc);
            chk("R2", "ack_drive at decision", ack_drive, mon_e.ack);
         end
      end
   end

   task automatic write_cfg(bit [17:0] w);
      cfg_we = 1; cfg_wdata = w;
      @(negedge clk);
      cfg_we = 0;
      if (m_en) m_en = w[0];
      else begin m_en = w[0]; m_lsn = w[1]; m_auto = w[2]; m_map = w[17:3]; end
   endtask

   task automatic send_bit(bit b);
      bit_vld = 1; bit_val = b;
      @(negedge clk);
      bit_vld = 0;
      @(negedge clk);
   endtask

   task automatic send_header(string req, bit [3:0] i, bit [3:0] d);
      exp_t e;
      e = predict(i, d);
      if (!m_en) begin e.acc = 0; e.ack = 0; end
      else exp_q.push_back(e);
      for (int k = 3; k >= 0; k--) send_bit(i[k]);
      for (int k = 3; k >= 0; k--) send_bit(d[k]);
      send_bit(1'b0);
      chk(req, "ack_drive before ACK slot", ack_drive, e.ack);
      chk(req, "rx_accept before ACK slot", rx_accept, e.acc);
      send_bit(1'b1);
      chk("R3", "ack_drive after ACK slot", ack_drive, 0);
      chk("R3", "rx_accept after ACK slot", rx_accept, e.acc);
   endtask

   task automatic end_msg(output logic sft);
      msg_done = 1;
      @(negedge clk);
      msg_done = 0;
      sft = sft_start;
      @(negedge clk);
   endtask

   task automatic som(output logic sft);
      tx_som = 1;
      @(negedge clk);
      tx_som = 0;
      sft = sft_start;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic s;
      rst_n = 0; cfg_we = 0; cfg_wdata = '0;
      bit_vld = 0; bit_val = 0; msg_done = 0; tx_som = 0;
      m_en = 0; m_lsn = 0; m_auto = 0; m_map = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "rx_accept", rx_accept, 0);
      chk("R1", "ack_drive", ack_drive, 0);
      chk("R1", "addresses", {init_addr, dest_addr}, 0);
      chk("R1", "sft_start", sft_start, 0);
      // R1 disabled: a broadcast header and events do nothing
      send_header("R1", 4'h1, 4'hF);
      som(s);
      chk("R1", "sft while disabled", s, 0);

      // own match, MSB-first capture
      write_cfg(mk(1, 0, 0, 15'h0021));
      send_header("R2", 4'h4, 4'h5);
      end_msg(s);
      chk("R10", "msg_done clears accept", rx_accept, 0);
      chk("R11", "msg_done with option 0", s, 0);
      // R4 foreign, listen off
      send_header("R4", 4'h4, 4'h6);
      end_msg(s);
      // R6 broadcast
      send_header("R6", 4'h2, 4'hF);
      end_msg(s);
      // R11 option 0: tx_som triggers
      som(s);
      chk("R11", "tx_som with option 0", s, 1);

      // R8 write while enabled: fields ignored
      write_cfg(mk(1, 1, 1, 15'h0000));
      send_header("R8", 4'h1, 4'h6);
      end_msg(s);
      send_header("R8", 4'h1, 4'h0);
      end_msg(s);
      chk("R8", "option unchanged, msg_done no trigger", s, 0);

      // reconfigure while off: listen on, auto trigger, map addr 3
      write_cfg(mk(0, 0, 0, 15'h0000));
      write_cfg(mk(1, 1, 1, 15'h0008));
      send_header("R5", 4'h9, 4'h7);
      end_msg(s);
      chk("R11", "msg_done with option 1", s, 1);
      send_header("R2", 4'h9, 4'h3);
      // R10 data bits after the ACK slot
      for (int k = 0; k < 3; k++) send_bit(1'b0);
      chk("R10", "accept held through data", rx_accept, 1);
      end_msg(s);
      send_header("R6", 4'h7, 4'hF);
      end_msg(s);
      som(s);
      chk("R11", "tx_som with option 1", s, 0);

      // R9 abort a partial header
      for (int k = 0; k < 5; k++) send_bit(1'b1);
      write_cfg(mk(0, 0, 0, 15'h0000));
      @(negedge clk);
      chk("R9", "accept after abort", rx_accept, 0);
      write_cfg(mk(1, 0, 0, 15'h0008));
      send_header("R9", 4'hC, 4'h3);
      // R9 disable while a message is accepted
      write_cfg(mk(0, 0, 0, 15'h0000));
      @(negedge clk);
      chk("R9", "accept cleared by disable", rx_accept, 0);
      chk("R9", "ack cleared by disable", ack_drive, 0);
      end_msg(s);
      chk("R11", "no trigger while disabled", s, 0);

      repeat (3) @(negedge clk);
      chk("R3", "all predicted decisions seen", exp_q.size(), 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule